// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block holds the 6-bit position of a digitally controlled resistor wiper and decodes it into a one-hot select. The select closes exactly one of 64 tap switches. Four sources can load the position. A recall copies the value of data register 0. A direct write loads a host value. A copy loads the content of one of four data registers. A step moves the position by one, up or down. The current position is always visible on `pos_o`, so it can be read back or saved into a data register.

The position is volatile. Reset clears it to zero, and on the first clock after reset the block performs a recall from data register 0. A settle flag falls whenever the position changes. It rises again once a parameterised number of clock cycles has passed with no further change, which lets the surrounding logic wait out the analogue response time.

The three host-driven load channels use valid/ready. A channel's data is taken on a clock edge where both its valid and its ready are high. Ready expresses priority only: a channel is held off in any cycle where a higher-priority source is active. The order from highest to lowest is recall, direct write, copy, step. Ready never depends on the channel's own valid. A held-off channel keeps valid and data stable until it is accepted, or it withdraws the request.

Top module: `wiper_pos_reg`

## Requirements
- R1: `tap_o` has exactly one bit set at all times. That bit's index equals `pos_o`: bit 0 is the low end (code 00h) and bit 63 is the high end (code 3Fh).
- R2: While reset is active, `pos_o` is 0 and `settled_o` is 0. On the first clock edge after reset is released, `pos_o` loads `dr0_i`, and in that cycle all three readies are low.
- R3: An accepted direct write sets `pos_o` to `wr_data` one clock after the accepting edge.
- R4: An accepted copy sets `pos_o` to data register `cp_sel`, which is taken from bits [6*cp_sel+5 : 6*cp_sel] of `dr_bus`, one clock after the accepting edge.
- R5: An accepted step with `step_up`=1 adds one to `pos_o`. With `step_up`=0 it subtracts one.
- R6: An up step at 3Fh leaves `pos_o` at 3Fh. A down step at 00h leaves it at 00h.
- R7: Priority is recall (`recall_i` or the post-reset recall), then direct write, then copy, then step. `wr_ready` is low while a recall is active. `cp_ready` is also low while `wr_valid` is high. `step_ready` is also low while `cp_valid` is high.
- R8: `settled_o` is low in every cycle right after `pos_o` changes. It rises exactly SETTLE_CYC clocks after the changing edge if no further change occurs. A load that leaves the value unchanged does not lower it.
- R9: A pulse on `recall_i` reloads `pos_o` from `dr0_i` one clock later, even when a write is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Request a reload from data register 0 |
| dr0_i | input | 6 | Current value of data register 0 |
| wr_valid | input | 1 | Direct write request |
| wr_ready | output | 1 | Direct write can be taken this cycle |
| wr_data | input | 6 | Direct write value |
| cp_valid | input | 1 | Copy request |
| cp_ready | output | 1 | Copy can be taken this cycle |
| cp_sel | input | 2 | Index of the data register to copy |
| dr_bus | input | 24 | The four data register values, register i in bits [6i+5:6i] |
| step_valid | input | 1 | Single-step request |
| step_ready | output | 1 | Step can be taken this cycle |
| step_up | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| pos_o | output | 6 | Current position, for readback and saving |
| tap_o | output | 64 | One-hot tap switch enables |
| settled_o | output | 1 | High when the position has been stable for SETTLE_CYC clocks |

## Verification
The position register drives both `pos_o` and `tap_o` with no pipeline stage in between. A wrong next-state choice therefore shows on the ports one clock after the faulty edge. Such a choice could be a missed clamp, a wrong priority or a wrong register slice. The reference model compares the position, the tap vector, the readies and the settle flag on every cycle, so the first bad edge is reported. A settle counter that is wrong or loaded at the wrong time shows up within SETTLE_CYC+1 clocks, because `settled_o` rises early, rises late, or fails to drop.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int POS_W   = 6;
  localparam int NUM_TAP = 1 << POS_W;
  typedef logic [POS_W-1:0] pos_t;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RECALL,
    SRC_WRITE,
    SRC_COPY,
    SRC_STEP
  } src_e;
endpackage

// File: rtl/wiper_step.sv
module wiper_step
  import wiper_pkg::*;
(
  input  pos_t cur,
  input  logic up,
  output pos_t nxt
);
  localparam pos_t TOP = '1;
  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + pos_t'(1);
    else    nxt = (cur == '0)  ? cur : cur - pos_t'(1);
  end
endmodule

// File: rtl/wiper_src_arb.sv
module wiper_src_arb
  import wiper_pkg::*;
#(
  parameter int NUM_DR = 4,
  localparam int SEL_W = $clog2(NUM_DR)
) (
  input  logic                    recall_any,
  input  pos_t                    dr0,
  input  logic                    wr_valid,
  input  pos_t                    wr_data,
  input  logic                    cp_valid,
  input  logic [SEL_W-1:0]        cp_sel,
  input  logic [NUM_DR*POS_W-1:0] dr_bus,
  input  logic                    step_valid,
  input  pos_t                    step_val,
  output logic                    wr_ready,
  output logic                    cp_ready,
  output logic                    step_ready,
  output logic                    load_en,
  output pos_t                    load_val,
  output src_e                    src
);
  pos_t dr_arr [NUM_DR];
  for (genvar g = 0; g < NUM_DR; g++) begin : g_unpack
    assign dr_arr[g] = dr_bus[g*POS_W +: POS_W];
  end

  assign wr_ready   = !recall_any;
  assign cp_ready   = wr_ready && !wr_valid;
  assign step_ready = cp_ready && !cp_valid;

  always_comb begin
    src = SRC_NONE;
    if (recall_any)                    src = SRC_RECALL;
    else if (wr_valid)                 src = SRC_WRITE;
    else if (cp_valid)                 src = SRC_COPY;
    else if (step_valid && step_ready) src = SRC_STEP;
  end

  always_comb begin
    unique case (src)
      SRC_RECALL: load_val = dr0;
      SRC_WRITE:  load_val = wr_data;
      SRC_COPY:   load_val = dr_arr[cp_sel];
      SRC_STEP:   load_val = step_val;
      default:    load_val = '0;
    endcase
  end
  assign load_en = (src != SRC_NONE);
endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec
  import wiper_pkg::*;
(
  input  pos_t               pos,
  output logic [NUM_TAP-1:0] tap
);
  for (genvar i = 0; i < NUM_TAP; i++) begin : g_tap
    assign tap[i] = (pos == pos_t'(i));
  end
endmodule

// File: rtl/wiper_settle.sv
module wiper_settle #(
  parameter int SETTLE_CYC = 8,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic change,
  output logic settled
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);
  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= LOAD;
    else if (change)     cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end
  assign settled = (cnt_q == '0);
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int NUM_DR     = 4,
  parameter int SETTLE_CYC = 8,
  localparam int SEL_W     = $clog2(NUM_DR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    recall_i,
  input  logic [POS_W-1:0]        dr0_i,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [POS_W-1:0]        wr_data,
  input  logic                    cp_valid,
  output logic                    cp_ready,
  input  logic [SEL_W-1:0]        cp_sel,
  input  logic [NUM_DR*POS_W-1:0] dr_bus,
  input  logic                    step_valid,
  output logic                    step_ready,
  input  logic                    step_up,
  output logic [POS_W-1:0]        pos_o,
  output logic [NUM_TAP-1:0]      tap_o,
  output logic                    settled_o
);
  pos_t pos_q, step_val, load_val, pos_d;
  logic boot_q, load_en;
  src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  wiper_step u_step (.cur(pos_q), .up(step_up), .nxt(step_val));

  wiper_src_arb #(.NUM_DR(NUM_DR)) u_arb (
    .recall_any(boot_q | recall_i), .dr0(dr0_i),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .cp_valid(cp_valid), .cp_sel(cp_sel), .dr_bus(dr_bus),
    .step_valid(step_valid), .step_val(step_val),
    .wr_ready(wr_ready), .cp_ready(cp_ready), .step_ready(step_ready),
    .load_en(load_en), .load_val(load_val), .src(src)
  );

  assign pos_d = load_en ? load_val : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  wiper_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .change(pos_d != pos_q), .settled(settled_o)
  );

  wiper_tap_dec u_dec (.pos(pos_q), .tap(tap_o));

  assign pos_o = pos_q;
endmodule

// File: rtl/wiper_pos_reg_chk.sv
module wiper_pos_reg_chk
  import wiper_pkg::*;
#(
  parameter int NUM_DR = 4,
  localparam int SEL_W = $clog2(NUM_DR)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    recall_i,
  input logic [POS_W-1:0]        dr0_i,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [POS_W-1:0]        wr_data,
  input logic                    cp_valid,
  input logic                    cp_ready,
  input logic [SEL_W-1:0]        cp_sel,
  input logic [NUM_DR*POS_W-1:0] dr_bus,
  input logic                    step_valid,
  input logic                    step_ready,
  input logic                    step_up,
  input logic [POS_W-1:0]        pos_o,
  input logic [NUM_TAP-1:0]      tap_o,
  input logic                    settled_o
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_o) == 1);
  p_tap_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[pos_o]);
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> pos_o == $past(wr_data));
  p_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && cp_ready |=> pos_o == $past(dr_bus[cp_sel*POS_W +: POS_W]));
  p_sat_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && step_up && pos_o == '1 |=> pos_o == '1);
  p_sat_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_ready && !step_up && pos_o == '0 |=> pos_o == '0);
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recall_i |-> !wr_ready && !cp_ready && !step_ready);
  p_recall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall_i |=> pos_o == $past(dr0_i));
  p_settle_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o != $past(pos_o) |-> !settled_o);
endmodule

bind wiper_pos_reg wiper_pos_reg_chk #(.NUM_DR(NUM_DR)) u_chk (.*);

// File: tb/wiper_pos_reg_test.sv
module wiper_pos_reg_test;
  localparam int S = 8;
  logic clk = 0, rst_n = 0;
  logic recall_i = 0, wr_valid = 0, cp_valid = 0, step_valid = 0, step_up = 0;
  logic [5:0] dr0_i = 6'h15, wr_data = 0, pos_o;
  logic [1:0] cp_sel = 0;
  logic [23:0] dr_bus;
  logic [63:0] tap_o;
  logic wr_ready, cp_ready, step_ready, settled_o;
  int drs [4] = '{21, 7, 44, 63};
  int total = 0, bad = 0;
  int mpos, mcnt, mboot;
  string cur_req = "R2";

  always #10 clk = ~clk;
  always_comb dr_bus = {6'(drs[3]), 6'(drs[2]), 6'(drs[1]), 6'(drs[0])};
  always_comb dr0_i = 6'(drs[0]);

  wiper_pos_reg #(.SETTLE_CYC(S)) uut (.*);

  always @(posedge clk or negedge rst_n) begin
    int nxt;
    if (!rst_n) begin mpos = 0; mboot = 1; mcnt = S; end
    else begin
      nxt = mpos;
      if (mboot != 0 || recall_i) nxt = drs[0];
      else if (wr_valid) nxt = wr_data;
      else if (cp_valid) nxt = drs[cp_sel];
      else if (step_valid) nxt = step_up ? (mpos == 63 ? 63 : mpos + 1)
                                         : (mpos == 0 ? 0 : mpos - 1);
      mboot = 0;
      if (nxt != mpos) mcnt = S; else if (mcnt > 0) mcnt--;
      mpos = nxt;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    logic rec;
    rec = (mboot != 0) || recall_i;
    chk(cur_req, int'(pos_o), mpos);
    chk("R1", int'(tap_o == (64'b1 << mpos)), 1);
    chk("R8", int'(settled_o), int'(mcnt == 0));
    chk("R7", int'(wr_ready), int'(!rec));
    chk("R7", int'(cp_ready), int'(!rec && !wr_valid));
    chk("R7", int'(step_ready), int'(!rec && !wr_valid && !cp_valid));
  endtask

  task automatic tick(logic rc, logic wv, int wd, logic cv, int cs, logic sv, logic up);
    @(negedge clk);
    recall_i = rc; wr_valid = wv; wr_data = 6'(wd);
    cp_valid = cv; cp_sel = 2'(cs); step_valid = sv; step_up = up;
    #2 compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #30000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    #45;
    cur_req = "R2";
    chk("R2", int'(pos_o), 0);
    chk("R2", int'(settled_o), 0);
    @(negedge clk) rst_n = 1;
    #2 compare();
    idle(S + 3);
    cur_req = "R3"; tick(0, 1, 62, 0, 0, 0, 0); idle(2);
    cur_req = "R6"; for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 1, 1);
    idle(S + 2);
    cur_req = "R4"; tick(0, 0, 0, 1, 2, 0, 0); idle(1);
    tick(0, 0, 0, 1, 1, 0, 0); idle(1);
    cur_req = "R5"; for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0, 1, 1);
    cur_req = "R3"; tick(0, 1, 1, 0, 0, 0, 0);
    cur_req = "R6"; for (int i = 0; i < 3; i++) tick(0, 0, 0, 0, 0, 1, 0);
    cur_req = "R7"; tick(0, 1, 30, 1, 3, 1, 1); tick(0, 0, 0, 1, 3, 1, 0);
    cur_req = "R9"; tick(1, 1, 50, 1, 2, 1, 1); idle(S + 1);
    cur_req = "R8"; tick(0, 1, 21, 0, 0, 0, 0); idle(3);
    lfsr = 16'hACE1;
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[15:12] == 0, lfsr[11:9] == 0, int'(lfsr[5:0]),
           lfsr[8:7] == 0, int'(lfsr[3:2]), lfsr[6], lfsr[4]);
    end
    idle(S + 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule